// File: doc/BRIEF.md
# Low-Voltage Detect Interrupt Register

This block is the register slice of a microcontroller peripheral that watches the supply voltage and collects three interrupt sources together with their wake-up enables. Software programs a small control field: one bit turns the detector on and a 2-bit select picks one of four supply thresholds. The digital outputs of the analog comparators, one per threshold, enter through a synchronizer. The selected, enabled comparator drives a live active-low status bit. Its first assertion latches the low-voltage interrupt flag.

A second 8-bit register holds the live status bit, three sticky interrupt flags (low voltage, ADC done, comparator) and four wake-up enables (ADC, comparator, input change, low voltage). Hardware sets the flags. Software can only clear them. Every read of this register is filtered through a separate interrupt mask. The block produces a level interrupt request for the core and a wake-up request for the sleep controller.

Top module: `lvd_irq_reg`

## Requirements
- R1: After reset all flags and wake-up enables are 0, the enable is 0 and the threshold select is 00. With an all-ones mask the status register reads 0x80 and the control field reads 0x00.
- R2: A control write stores wrData[2] as the detector enable and wrData[1:0] as the threshold select. ctlRdData returns them in bits 2:0 and returns 0 in bits 7:3.
- R3: Threshold select value v picks comparator input cmpLow[v], where 1 means the supply is below that level. 11 is 2.3 V, 10 is 3.3 V, 01 is 4.0 V and 00 is 4.5 V.
- R4: Status bit 7 reads 0 from the second clock edge after the selected comparator input goes high while the detector is enabled. It reads 1 when the detector is disabled or that input is low. Writes never change it.
- R5: The low-voltage flag (bit 6) is set on the clock edge at which the synchronized, selected and enabled low indication first rises. It then stays set until software clears it.
- R6: A status write clears each flag in bits 6:4 whose write-data bit is 0. A write-data bit of 1 leaves that flag unchanged, so software cannot set a flag.
- R7: A hardware set of a flag takes priority over a software clear of that flag in the same cycle.
- R8: A one-cycle high on adcEvent sets the ADC flag (bit 5), and a one-cycle high on cmpEvent sets the comparator flag (bit 4), at that clock edge.
- R9: statRdData is the bitwise AND of the status register and irqMask.
- R10: A status write stores wrData[3:0] as the wake-up enables. Bit 3 is ADC, bit 2 is comparator, bit 1 is input change and bit 0 is low voltage.
- R11: irqReq is high when any flag is 1 and its mask bit (6, 5 or 4) is 1. The low-voltage flag additionally requires wake-up enable bit 0.
- R12: wakeReq is high when the low-voltage flag and bit 0 are set, the ADC flag and bit 3 are set, the comparator flag and bit 2 are set, or icEvent and bit 1 are high. The icEvent path is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlWr | input | 1 | Write strobe for the control field |
| statWr | input | 1 | Write strobe for the status/wake-up register |
| wrData | input | 8 | CPU write data |
| irqMask | input | 8 | Interrupt mask register contents |
| cmpLow | input | 4 | Asynchronous comparator outputs, one per threshold |
| adcEvent | input | 1 | ADC conversion-done pulse |
| cmpEvent | input | 1 | Comparator event pulse |
| icEvent | input | 1 | Input-change wake event |
| ctlRdData | output | 8 | Control field read data |
| statRdData | output | 8 | Status register read data, masked |
| irqReq | output | 1 | Interrupt request |
| wakeReq | output | 1 | Sleep wake-up request |

## Verification
On every cycle the assertions check these properties: the set pulse is a single cycle and only occurs while the detector is enabled, a hardware set lands in the flags, no flag rises without a set strobe, the status bit stays high while the detector is off, and neither request can rise without a mask bit or a wake enable. Only the bench scenarios can show the exact two-edge synchronizer latency and the mapping of each select code to its comparator input. The same holds for the collision of a clear write with a set edge and the masked read values. A randomized run compares all four outputs against a cycle model.

// File: rtl/lvd_irq_pkg.sv
package lvd_irq_pkg;
  localparam int DATA_W = 8;
  // Status register field positions (software decodes these)
  localparam int ST_LOWN   = 7;
  localparam int ST_FLAG_H = 6;
  localparam int ST_FLAG_L = 4;
  localparam int NUM_FLAGS = 3;
  localparam int NUM_WAKE  = 4;
  // Flag vector order: [2]=low voltage, [1]=ADC, [0]=comparator
  localparam int F_LVD = 2;
  localparam int F_ADC = 1;
  localparam int F_CMP = 0;
  // Wake enable order: [3]=ADC, [2]=comparator, [1]=input change, [0]=low voltage
  localparam int W_ADC = 3;
  localparam int W_CMP = 2;
  localparam int W_IC  = 1;
  localparam int W_LVD = 0;

  typedef struct packed {
    logic                 ctlLoad;
    logic                 wakeLoad;
    logic [NUM_FLAGS-1:0] clrFlags;
    logic [NUM_FLAGS-1:0] setFlags;
    logic                 lvdLow;
  } strobe_t;
endpackage

// File: rtl/lvd_irq_ctrl.sv
module lvd_irq_ctrl
  import lvd_irq_pkg::*;
#(
  parameter int NUM_LEVELS  = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ctlWr,
  input  logic                  statWr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_LEVELS-1:0] cmpLow,
  input  logic                  adcEvent,
  input  logic                  cmpEvent,
  input  logic                  ctlEn,
  input  logic [SEL_W-1:0]      ctlSel,
  output strobe_t               strobe
);
  logic [NUM_LEVELS-1:0] syncQ [SYNC_STAGES];
  logic lowNow;
  logic lowPrev;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[g] <= '0;
          else       syncQ[g] <= cmpLow;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[g] <= '0;
          else       syncQ[g] <= syncQ[g-1];
      end
    end
  endgenerate

  assign lowNow = ctlEn & syncQ[SYNC_STAGES-1][ctlSel];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) lowPrev <= 1'b0;
    else       lowPrev <= lowNow;

  always_comb begin
    strobe                 = '0;
    strobe.ctlLoad         = ctlWr;
    strobe.wakeLoad        = statWr;
    strobe.clrFlags        = statWr ? ~wrData[ST_FLAG_H:ST_FLAG_L] : '0;
    strobe.setFlags[F_LVD] = lowNow & ~lowPrev;
    strobe.setFlags[F_ADC] = adcEvent;
    strobe.setFlags[F_CMP] = cmpEvent;
    strobe.lvdLow          = lowNow;
  end

  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setFlags[F_LVD] |-> ctlEn); // R5
  AST_SET_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setFlags[F_LVD] |=> !strobe.setFlags[F_LVD]); // R5
endmodule

// File: rtl/lvd_irq_dp.sv
module lvd_irq_dp
  import lvd_irq_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] irqMask,
  input  logic              icEvent,
  output logic              ctlEn,
  output logic [SEL_W-1:0]  ctlSel,
  output logic [DATA_W-1:0] ctlRdData,
  output logic [DATA_W-1:0] statRdData,
  output logic              irqReq,
  output logic              wakeReq
);
  localparam int CTL_PAD = DATA_W - SEL_W - 1;

  logic [NUM_FLAGS-1:0] flags;
  logic [NUM_WAKE-1:0]  wakeEn;
  logic                 statusN;
  logic [DATA_W-1:0]    statReg;
  logic [NUM_FLAGS-1:0] flagMask;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      ctlEn  <= 1'b0;
      ctlSel <= '0;
    end else if (strobe.ctlLoad) begin
      ctlEn  <= wrData[SEL_W];
      ctlSel <= wrData[SEL_W-1:0];
    end

  // Set wins over clear: clear first, then OR in the set pulses
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~strobe.clrFlags) | strobe.setFlags;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                wakeEn <= '0;
    else if (strobe.wakeLoad) wakeEn <= wrData[NUM_WAKE-1:0];

  assign statusN    = ~strobe.lvdLow;
  assign statReg    = {statusN, flags, wakeEn};
  assign statRdData = statReg & irqMask;
  assign ctlRdData  = {{CTL_PAD{1'b0}}, ctlEn, ctlSel};
  assign flagMask   = irqMask[ST_FLAG_H:ST_FLAG_L];

  assign irqReq  = (flags[F_LVD] & flagMask[F_LVD] & wakeEn[W_LVD])
                 | (flags[F_ADC] & flagMask[F_ADC])
                 | (flags[F_CMP] & flagMask[F_CMP]);
  assign wakeReq = (flags[F_LVD] & wakeEn[W_LVD])
                 | (flags[F_ADC] & wakeEn[W_ADC])
                 | (flags[F_CMP] & wakeEn[W_CMP])
                 | (icEvent      & wakeEn[W_IC]);

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flags & $past(strobe.setFlags)) == $past(strobe.setFlags))); // R7
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(strobe.setFlags)) == '0)); // R6
  AST_STATUS_HIGH_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !ctlEn |-> statusN); // R4
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (flagMask != '0)); // R11
  AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (wakeEn != '0)); // R12
endmodule

// File: rtl/lvd_irq_reg.sv
module lvd_irq_reg
  import lvd_irq_pkg::*;
#(
  parameter int NUM_LEVELS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ctlWr,
  input  logic                  statWr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [DATA_W-1:0]     irqMask,
  input  logic [NUM_LEVELS-1:0] cmpLow,
  input  logic                  adcEvent,
  input  logic                  cmpEvent,
  input  logic                  icEvent,
  output logic [DATA_W-1:0]     ctlRdData,
  output logic [DATA_W-1:0]     statRdData,
  output logic                  irqReq,
  output logic                  wakeReq
);
  localparam int SEL_W = $clog2(NUM_LEVELS);

  strobe_t          strobe;
  logic             ctlEn;
  logic [SEL_W-1:0] ctlSel;

  lvd_irq_ctrl #(
    .NUM_LEVELS (NUM_LEVELS),
    .SYNC_STAGES(SYNC_STAGES),
    .SEL_W      (SEL_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ctlWr   (ctlWr),
    .statWr  (statWr),
    .wrData  (wrData),
    .cmpLow  (cmpLow),
    .adcEvent(adcEvent),
    .cmpEvent(cmpEvent),
    .ctlEn   (ctlEn),
    .ctlSel  (ctlSel),
    .strobe  (strobe)
  );

  lvd_irq_dp #(
    .SEL_W(SEL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .irqMask   (irqMask),
    .icEvent   (icEvent),
    .ctlEn     (ctlEn),
    .ctlSel    (ctlSel),
    .ctlRdData (ctlRdData),
    .statRdData(statRdData),
    .irqReq    (irqReq),
    .wakeReq   (wakeReq)
  );
endmodule

// File: tb/lvd_irq_reg_bench.sv
module lvd_irq_reg_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctlWr = 1'b0, statWr = 1'b0;
  logic [7:0] wrData = '0, irqMask = 8'hFF;
  logic [3:0] cmpLow = '0;
  logic       adcEvent = 1'b0, cmpEvent = 1'b0, icEvent = 1'b0;
  logic [7:0] ctlRdData, statRdData;
  logic       irqReq, wakeReq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvd_irq_reg u_lvd_irq_reg (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .statWr(statWr), .wrData(wrData),
    .irqMask(irqMask), .cmpLow(cmpLow), .adcEvent(adcEvent), .cmpEvent(cmpEvent),
    .icEvent(icEvent), .ctlRdData(ctlRdData), .statRdData(statRdData),
    .irqReq(irqReq), .wakeReq(wakeReq)
  );

  // Cycle model built from the requirements
  logic [3:0] mS1, mS2, mWake;
  logic [2:0] mFlags;
  logic [1:0] mSel;
  logic       mEn, mLowPrev;

  always @(posedge clk or negedge rstN) begin
    logic lowNow;
    if (!rstN) begin
      mS1 = '0; mS2 = '0; mWake = '0; mFlags = '0; mSel = '0; mEn = 0; mLowPrev = 0;
    end else begin
      lowNow = mEn & mS2[mSel];
      if (statWr) mFlags = mFlags & wrData[6:4];
      mFlags = mFlags | {lowNow & ~mLowPrev, adcEvent, cmpEvent};
      mLowPrev = lowNow;
      if (statWr) mWake = wrData[3:0];
      if (ctlWr) begin mEn = wrData[2]; mSel = wrData[1:0]; end
      mS2 = mS1;
      mS1 = cmpLow;
    end
  end

  function automatic logic [7:0] expStat();
    return {~(mEn & mS2[mSel]), mFlags, mWake} & irqMask;
  endfunction
  function automatic logic expIrq();
    return (mFlags[2] & irqMask[6] & mWake[0]) | (mFlags[1] & irqMask[5]) | (mFlags[0] & irqMask[4]);
  endfunction
  function automatic logic expWake();
    return (mFlags[2] & mWake[0]) | (mFlags[1] & mWake[3]) | (mFlags[0] & mWake[2]) | (icEvent & mWake[1]);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrStat(logic [7:0] v);
    statWr = 1'b1; wrData = v; tick(); statWr = 1'b0;
  endtask

  task automatic wrCtl(logic [7:0] v);
    ctlWr = 1'b1; wrData = v; tick(); ctlWr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    // R1 reset values
    chk("R1 stat", statRdData, 8'h80);
    chk("R1 ctl", ctlRdData, 8'h00);
    chk("R1 irq", {7'd0, irqReq}, 8'h00);
    // R2 control field
    wrCtl(8'hFF);
    chk("R2 ctl upper bits zero", ctlRdData, 8'h07);
    // R3 select 11 -> cmpLow[3] only; drive lower three levels low-supply
    cmpLow = 4'b0111; tick(); tick(); tick();
    chk("R3 sel11 ignores lower levels", statRdData, 8'h80);
    wrCtl(8'h06);
    chk("R3 sel10 uses cmpLow[2]", statRdData, 8'h00);
    tick();
    chk("R5 flag after first low", statRdData, 8'h40);
    // R4 latency
    cmpLow = 4'b0000; tick(); tick(); tick();
    wrStat(8'h01);
    chk("R6 write 0 clears flag", statRdData, 8'h81);
    cmpLow = 4'b0100; tick();
    chk("R4 one edge: still high", statRdData, 8'h81);
    tick();
    chk("R4 two edges: low", statRdData, 8'h01);
    tick();
    chk("R5 flag set", statRdData, 8'h41);
    chk("R11 irq with wake bit0", {7'd0, irqReq}, 8'h01);
    chk("R12 wake from lvd", {7'd0, wakeReq}, 8'h01);
    tick(); tick();
    chk("R5 flag stays set", statRdData, 8'h41);
    irqMask = 8'hBF; #1;
    chk("R9 masked read", statRdData, 8'h01);
    chk("R11 irq masked off", {7'd0, irqReq}, 8'h00);
    irqMask = 8'hFF;
    wrStat(8'hF1);
    chk("R6 write 1 no set, bit7 ignored", statRdData, 8'h41);
    // R7 set and clear in same cycle
    cmpLow = 4'b0000; tick(); tick(); tick();
    wrStat(8'h01);
    chk("R7 prep", statRdData, 8'h81);
    cmpLow = 4'b0100; tick(); tick();
    wrStat(8'h01);
    chk("R7 set beats clear", statRdData, 8'h41);
    // R8 event flags, R10 wake enables
    wrStat(8'h0C);
    chk("R10 wake enables", statRdData, 8'h0C);
    adcEvent = 1'b1; tick(); adcEvent = 1'b0;
    chk("R8 adc flag", statRdData, 8'h2C);
    chk("R12 wake from adc", {7'd0, wakeReq}, 8'h01);
    cmpEvent = 1'b1; statWr = 1'b1; wrData = 8'h0C; tick(); statWr = 1'b0; cmpEvent = 1'b0;
    chk("R8 cmp flag, R7 with clear", statRdData, 8'h1C);
    wrStat(8'h02);
    chk("R12 idle", {7'd0, wakeReq}, 8'h00);
    icEvent = 1'b1; #1;
    chk("R12 input change wake", {7'd0, wakeReq}, 8'h01);
    icEvent = 1'b0;
    // Random phase against the model
    for (int i = 0; i < 600; i++) begin
      ctlWr    = ($urandom % 8) == 0;
      statWr   = ($urandom % 6) == 0;
      wrData   = 8'($urandom);
      adcEvent = ($urandom % 10) == 0;
      cmpEvent = ($urandom % 10) == 0;
      icEvent  = ($urandom % 4) == 0;
      if (($urandom % 12) == 0) cmpLow = 4'($urandom);
      if (($urandom % 16) == 0) irqMask = 8'($urandom);
      tick();
      chk("R9 R3 R4 R5 random stat", statRdData, expStat());
      chk("R2 random ctl", ctlRdData, {5'd0, mEn, mSel});
      chk("R11 random irq", {7'd0, irqReq}, {7'd0, expIrq()});
      chk("R12 random wake", {7'd0, wakeReq}, {7'd0, expWake()});
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule